// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block turns one interrupt message into the set of local interrupt controllers that should receive it. It serves a group of `N` controllers. Each controller has three things: an index given by its position, a physical ID that arrives on a flat input bus, and a logical byte and a 4-bit addressing model that the block keeps in its own registers. A request brings a command word and a destination byte. The command word carries the vector, the delivery kind, the physical/logical selector and the shorthand. One cycle after the request strobe, the block presents a registered target mask, a no-target flag, and a one-hot pick for lowest-priority delivery.

In physical addressing the destination byte is compared with each controller's ID. In logical addressing each controller applies its own model, either flat or cluster. The shorthand field can bypass the destination byte altogether and aim at the sender, at everyone, or at everyone except the sender. The block does not signal interrupts, does not arbitrate priority between processors, and does not decode message addresses. The surrounding fabric does all of that with the mask.

Top module: `dest_resolver`

## Requirements
- R1: In physical mode with shorthand 0, the destination value 0xFF selects all N controllers.
- R2: In physical mode with shorthand 0, any other destination selects the lowest-indexed controller whose physical ID equals it. If no ID equals it, the mask is empty.
- R3: In logical mode, a controller with model 0xF (flat) is selected when the destination AND its logical byte is nonzero.
- R4: In logical mode, a controller with model 0x0 (cluster) is selected only when the upper nibbles of the destination and the logical byte are equal and their lower nibbles share at least one set bit.
- R5: In logical mode, a controller whose model is neither 0xF nor 0x0 is never selected, whatever its logical byte.
- R6: Shorthand 1 selects only the sender's index. The destination byte and the mode bit have no effect.
- R7: Shorthand 2 selects every controller including the sender. Shorthand 3 selects every controller except the sender.
- R8: Command word fields: shorthand in bits [19:18], physical(0)/logical(1) in bit 11, delivery kind in bits [10:8], vector in bits [7:0]. The vector and the delivery kind are returned with the result.
- R9: For delivery kind 1 (lowest priority), the lowpri output is one-hot on the lowest-indexed bit of the mask, or zero if the mask is empty. For any other kind it is zero.
- R10: Logical byte writes take cfg_wdata[31:24]. Model writes take cfg_wdata[31:28]. Each write changes only its own field. After reset every model is 0xF and every logical byte is 0.
- R11: The result registers load on the clock edge that samples req_valid. res_valid is high for exactly that following cycle. The outputs hold while no request arrives.
- R12: res_none is high exactly when the loaded mask is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ldr_we | input | 1 | Write the logical byte of controller cfg_idx |
| cfg_model_we | input | 1 | Write the addressing model of controller cfg_idx |
| cfg_idx | input | $clog2(N) | Controller index for a configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| phys_ids | input | 8*N | Physical IDs; controller i at bits [8i+7:8i] |
| req_valid | input | 1 | Request strobe |
| req_cmd | input | 32 | Command word |
| req_dest | input | 8 | Destination byte |
| req_sender | input | $clog2(N) | Index of the sending controller |
| res_valid | output | 1 | Result present this cycle |
| res_mask | output | N | Target mask |
| res_lowpri | output | N | One-hot lowest-priority pick |
| res_none | output | 1 | Mask is empty |
| res_vector | output | 8 | Vector of the resolved request |
| res_dlv | output | 3 | Delivery kind of the resolved request |

## Verification
Every result is due in the cycle after the strobe. The bench raises req_valid on a falling edge and drops it on the next falling edge. It then compares mask, lowpri, no-target flag, vector and delivery kind at that second falling edge, which is half a cycle after the one register stage has loaded. A configuration write becomes visible to a request issued at or after the falling edge that ends the write. The bench therefore always finishes a write before it sends the request that depends on it. The hold check looks at the outputs one full idle cycle later, when res_valid must already be low.

// File: rtl/dest_resolver.sv
module dest_resolver #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_ldr_we,
  input  logic            cfg_model_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [31:0]     cfg_wdata,
  input  logic [N*8-1:0]  phys_ids,
  input  logic            req_valid,
  input  logic [31:0]     req_cmd,
  input  logic [7:0]      req_dest,
  input  logic [IW-1:0]   req_sender,
  output logic            res_valid,
  output logic [N-1:0]    res_mask,
  output logic [N-1:0]    res_lowpri,
  output logic            res_none,
  output logic [7:0]      res_vector,
  output logic [2:0]      res_dlv
);

  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [7:0]   ldr_q   [N];
  logic [3:0]   model_q [N];
  logic [N-1:0] phys_hit, log_hit, phys_first, sender_bit, match, lp_pick;

  wire [1:0] shorthand = req_cmd[19:18];
  wire       log_mode  = req_cmd[11];
  wire [2:0] dlv       = req_cmd[10:8];

  for (genvar i = 0; i < N; i++) begin : g_ctl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ldr_q[i]   <= 8'h00;
        model_q[i] <= 4'hF;
      end else begin
        if (cfg_ldr_we && cfg_idx == IW'(i))   ldr_q[i]   <= cfg_wdata[31:24];
        if (cfg_model_we && cfg_idx == IW'(i)) model_q[i] <= cfg_wdata[31:28];
      end
    end

    assign phys_hit[i] = (phys_ids[i*8 +: 8] == req_dest);

    always_comb begin
      case (model_q[i])
        4'hF:    log_hit[i] = |(req_dest & ldr_q[i]);
        4'h0:    log_hit[i] = (req_dest[7:4] == ldr_q[i][7:4]) &&
                              (|(req_dest[3:0] & ldr_q[i][3:0]));
        default: log_hit[i] = 1'b0;
      endcase
    end
  end

  assign phys_first = phys_hit & (~phys_hit + ONE);
  assign sender_bit = ONE << req_sender;

  always_comb begin
    case (shorthand)
      2'd0:    match = log_mode ? log_hit : ((req_dest == 8'hFF) ? '1 : phys_first);
      2'd1:    match = sender_bit;
      2'd2:    match = '1;
      default: match = ~sender_bit;
    endcase
  end

  assign lp_pick = match & (~match + ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_mask   <= '0;
      res_lowpri <= '0;
      res_none   <= 1'b0;
      res_vector <= 8'h00;
      res_dlv    <= 3'd0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_mask   <= match;
        res_lowpri <= (dlv == 3'd1) ? lp_pick : '0;
        res_none   <= (match == '0);
        res_vector <= req_cmd[7:0];
        res_dlv    <= dlv;
      end
    end
  end

  // R11
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(res_mask) && $stable(res_lowpri)));
  // R9
  lowpri_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_lowpri) && ((res_lowpri & ~res_mask) == '0));
  // R7
  all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && shorthand == 2'd2) |=> (res_mask == '1));
  // R7
  others_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && shorthand == 2'd3) |=>
      (!res_mask[$past(req_sender)] && $countones(res_mask) == N - 1));
  // R2
  phys_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && shorthand == 2'd0 && !log_mode && req_dest != 8'hFF) |=>
      ($countones(res_mask) <= 1));
  // R12
  none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_none == (res_mask == '0)));

endmodule

// File: tb/dest_resolver_tb.sv
`timescale 1ns/1ps
module dest_resolver_tb;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_ldr_we = 1'b0, cfg_model_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [63:0] phys_ids = {8'h17, 8'h20, 8'h20, 8'h14, 8'h13, 8'h12, 8'h11, 8'h10};
  logic        req_valid = 1'b0;
  logic [31:0] req_cmd = '0;
  logic [7:0]  req_dest = '0;
  logic [2:0]  req_sender = '0;
  logic        res_valid, res_none;
  logic [7:0]  res_mask, res_lowpri, res_vector;
  logic [2:0]  res_dlv;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dest_resolver #(.N(N)) u_dut (
    .clk, .rst_n, .cfg_ldr_we, .cfg_model_we, .cfg_idx, .cfg_wdata, .phys_ids,
    .req_valid, .req_cmd, .req_dest, .req_sender,
    .res_valid, .res_mask, .res_lowpri, .res_none, .res_vector, .res_dlv);

  // {cmd, dest, sender, mask, lowpri, none}
  localparam logic [59:0] VEC [16] = '{
    {32'h00000041, 8'h12, 3'd0, 8'h04, 8'h00, 1'b0},  // R2 id match
    {32'h00000042, 8'hFF, 3'd0, 8'hFF, 8'h00, 1'b0},  // R1 broadcast
    {32'h00000043, 8'h20, 3'd0, 8'h20, 8'h00, 1'b0},  // R2 duplicate id, lowest
    {32'h00000044, 8'h99, 3'd0, 8'h00, 8'h00, 1'b1},  // R2 R12 no match
    {32'h00000845, 8'h05, 3'd0, 8'h05, 8'h00, 1'b0},  // R3 flat
    {32'h00000846, 8'h33, 3'd0, 8'h33, 8'h00, 1'b0},  // R3 R4 mixed
    {32'h00000847, 8'h34, 3'd0, 8'h04, 8'h00, 1'b0},  // R4 lower nibble miss
    {32'h00000848, 8'h41, 3'd0, 8'h41, 8'h00, 1'b0},  // R4 R5 odd model ignored
    {32'h00040049, 8'h12, 3'd3, 8'h08, 8'h00, 1'b0},  // R6 self
    {32'h0008004A, 8'h12, 3'd3, 8'hFF, 8'h00, 1'b0},  // R7 all
    {32'h000C004B, 8'h12, 3'd3, 8'hF7, 8'h00, 1'b0},  // R7 others
    {32'h000C004C, 8'h12, 3'd0, 8'hFE, 8'h00, 1'b0},  // R7 others, sender 0
    {32'h0000094D, 8'h33, 3'd0, 8'h33, 8'h01, 1'b0},  // R9 lowpri logical
    {32'h000C014E, 8'h00, 3'd0, 8'hFE, 8'h02, 1'b0},  // R9 lowpri others
    {32'h0000014F, 8'h99, 3'd0, 8'h00, 8'h00, 1'b1},  // R9 R12 lowpri empty
    {32'h00040950, 8'h05, 3'd6, 8'h40, 8'h40, 1'b0}   // R6 R8 self ignores dest/mode
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input bit ldr, input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_ldr_we = ldr; cfg_model_we = !ldr; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_ldr_we = 0; cfg_model_we = 0;
  endtask

  task automatic request(input logic [31:0] c, input logic [7:0] d, input logic [2:0] s);
    @(negedge clk);
    req_valid = 1; req_cmd = c; req_dest = d; req_sender = s;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 R12 reset state
    check(res_valid == 0 && res_mask == 0 && res_lowpri == 0 && res_none == 0,
          "R11 reset outputs", {res_valid, res_none, res_mask, res_lowpri}, 0);
    rst_n = 1;

    // R10 default flat model: only logical byte written
    cfg_write(1, 3'd0, 32'h01ABCDEF);
    request(32'h00000801, 8'h01, 3'd0);
    check(res_mask == 8'h01, "R10 default model flat", res_mask, 8'h01);
    request(32'h00000802, 8'h02, 3'd0);
    check(res_mask == 8'h00 && res_none, "R10 R12 default logical byte zero", res_mask, 8'h00);

    cfg_write(1, 3'd1, 32'h02000000);
    cfg_write(1, 3'd2, 32'h04000000);
    cfg_write(1, 3'd3, 32'h08000000);
    cfg_write(1, 3'd4, 32'h31000000);
    cfg_write(1, 3'd5, 32'h32000000);
    cfg_write(1, 3'd6, 32'h41000000);
    cfg_write(1, 3'd7, 32'hFF000000);
    cfg_write(0, 3'd4, 32'h0FFFFFFF);
    cfg_write(0, 3'd5, 32'h00000000);
    cfg_write(0, 3'd6, 32'h01234567);
    cfg_write(0, 3'd7, 32'h5FFFFFFF);

    for (int k = 0; k < 16; k++) begin
      logic [59:0] v;
      v = VEC[k];
      request(v[59:28], v[27:20], v[19:17]);
      check(res_valid, $sformatf("R11 valid vec%0d", k), res_valid, 1);
      check(res_mask == v[16:9], $sformatf("R1-7 mask vec%0d", k), res_mask, v[16:9]);
      check(res_lowpri == v[8:1], $sformatf("R9 lowpri vec%0d", k), res_lowpri, v[8:1]);
      check(res_none == v[0], $sformatf("R12 none vec%0d", k), res_none, v[0]);
      check(res_vector == v[35:28] && res_dlv == v[38:36], $sformatf("R8 fields vec%0d", k),
            {res_dlv, res_vector}, {v[38:36], v[35:28]});
    end

    // R11 pulse and hold
    @(negedge clk);
    check(!res_valid, "R11 valid one cycle", res_valid, 0);
    check(res_mask == 8'h40 && res_lowpri == 8'h40, "R11 hold", res_mask, 8'h40);

    // R10 model write keeps logical byte: controller 4 to flat (byte 0x31)
    cfg_write(0, 3'd4, 32'hF0000000);
    request(32'h00000811, 8'h41, 3'd0);
    check(res_mask == 8'h51, "R10 model rewrite", res_mask, 8'h51);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule